// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel. It watches the count of one of two free-running timers and drives a single output pin. A 3-bit mode field selects how the pin responds to equality between the count and the channel's compare registers. The modes are: off, drive high on match, drive low on match, toggle on match, one pulse, repeating pulses, and pulse-width modulation with or without a fault input. The timers, interrupt routing and pin multiplexing are outside the block. The block receives the two counts and their rollover strobes as inputs.

Software reaches the block through one write port. The port selects either the control register, the primary compare register or the secondary compare register. The control register can be read back at all times. A one-cycle event strobe marks each compare action that the active mode defines. A fault seen in the fault-enabled PWM mode is latched in hardware. The latch drives the pin to its inactive level until the control register is written again. An idle-stop control freezes the channel while the processor idles.

The parameter `CW` sets the width of the counts and compare registers. It must be at least 8.

Top module: `out_cmp_chan`

## Requirements
- R1: After reset the pin is low, the event strobe is low and the control readback is 0.
- R2: In mode 1 the pin starts low and is driven high, with an event strobe, in the cycle after the count equals the primary register.
- R3: In mode 2 the pin starts high and is driven low, with an event strobe, in the cycle after the count equals the primary register.
- R4: In mode 3 the pin starts low and inverts, with an event strobe, after every cycle in which the count equals the primary register.
- R5: Control bit 3 selects the timebase. With the bit at 0 the first timer count and first rollover strobe are used. With the bit at 1 the second timer's are used. A match on the unselected timer has no effect.
- R6: In mode 4 the pin starts low. It rises on a primary match and falls, with an event strobe, on a secondary match. The pulse is not repeated until the control register is written again.
- R7: Mode 5 behaves as mode 4, except that a new pulse starts on every primary match after a secondary match.
- R8: In modes 6 and 7 a rollover strobe does three things: it loads the duty register from the secondary register, raises an event strobe, and drives the pin high when the new duty is nonzero. A count equal to the duty value drives the pin low. A secondary register write between rollovers does not change the current duty.
- R9: In mode 6 the fault input has no effect on the pin or on the fault status bit.
- R10: In mode 7 a high fault input drives the pin low in the next cycle and sets the fault status bit. Both stay so until the next control write, even when a rollover strobe arrives in the same cycle as the fault.
- R11: A control write applies the new mode's initial pin level on the next clock and clears the fault status bit. The write takes priority over any compare match in the same cycle.
- R12: The control readback layout is: bits [2:0] mode, bit 3 timer select, bit 4 fault status, bit 5 idle stop, bits [7:6] zero. Writes to bits 4, 6 and 7 are ignored.
- R13: With idle stop set and the idle input high, the pin holds its level and no event is raised. With idle stop clear, the channel keeps running during idle.
- R14: In mode 0 the pin stays low and no event is raised, whatever the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr0_cnt | input | CW | First timer count |
| tmr1_cnt | input | CW | Second timer count |
| tmr0_wrap | input | 1 | First timer rollover strobe |
| tmr1_wrap | input | 1 | Second timer rollover strobe |
| cpu_idle | input | 1 | Processor idle indication |
| flt_in | input | 1 | Fault input, active high |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 control, 1 primary, 2 secondary |
| wr_data | input | CW | Write data |
| ctl_rd | output | 8 | Control register readback |
| pin_out | output | 1 | Channel output pin |
| cmp_evt | output | 1 | One-cycle compare event strobe |

## Verification
Two collisions can occur in a single cycle, and the bench provokes each one.

The first is a fault and a PWM period boundary in mode 7. The bench raises the fault input together with a rollover strobe. It expects the pin to stay low with no event strobe, and the readback to show the fault status bit set.

The second is a control write and a compare match. The bench writes the control register while the count equals the primary register. It expects the new mode's initial level, with no strobe, rather than the match action.

// File: rtl/out_cmp_chan.sv
module out_cmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tmr0_cnt,
  input  logic [CW-1:0] tmr1_cnt,
  input  logic          tmr0_wrap,
  input  logic          tmr1_wrap,
  input  logic          cpu_idle,
  input  logic          flt_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [7:0]    ctl_rd,
  output logic          pin_out,
  output logic          cmp_evt
);
  localparam logic [2:0] MD_OFF   = 3'd0;
  localparam logic [2:0] MD_SETHI = 3'd1;
  localparam logic [2:0] MD_SETLO = 3'd2;
  localparam logic [2:0] MD_TGL   = 3'd3;
  localparam logic [2:0] MD_ONE   = 3'd4;
  localparam logic [2:0] MD_CONT  = 3'd5;
  localparam logic [2:0] MD_PWM   = 3'd6;
  localparam logic [2:0] MD_PWMF  = 3'd7;

  logic [2:0]    mode;
  logic          tsel, istop, flt_st, done, pin_q, evt_q;
  logic [CW-1:0] pri, sec, duty;

  wire          ctl_wr  = wr_en && (wr_sel == 2'd0);
  wire [CW-1:0] cnt     = tsel ? tmr1_cnt : tmr0_cnt;
  wire          wrap    = tsel ? tmr1_wrap : tmr0_wrap;
  wire          hit_pri = (cnt == pri);
  wire          hit_sec = (cnt == sec);
  wire          hit_dty = (cnt == duty);
  wire          halted  = istop && cpu_idle;
  wire          flt_act = (mode == MD_PWMF) && (flt_in || flt_st);

  assign ctl_rd  = {2'b00, istop, flt_st, tsel, mode};
  assign pin_out = pin_q;
  assign cmp_evt = evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MD_OFF; tsel <= 1'b0; istop <= 1'b0; flt_st <= 1'b0;
      done <= 1'b0; pin_q <= 1'b0; evt_q <= 1'b0;
      pri <= '0; sec <= '0; duty <= '0;
    end else begin
      evt_q <= 1'b0;
      if (wr_en && wr_sel == 2'd1) pri <= wr_data;
      if (wr_en && wr_sel == 2'd2) sec <= wr_data;
      if (ctl_wr) begin
        mode   <= wr_data[2:0];
        tsel   <= wr_data[3];
        istop  <= wr_data[5];
        flt_st <= 1'b0;
        done   <= 1'b0;
        duty   <= sec;
        pin_q  <= (wr_data[2:0] == MD_SETLO);
      end else if (flt_act) begin
        pin_q  <= 1'b0;
        flt_st <= 1'b1;
      end else if (!halted) begin
        case (mode)
          MD_SETHI: if (hit_pri) begin pin_q <= 1'b1;   evt_q <= 1'b1; end
          MD_SETLO: if (hit_pri) begin pin_q <= 1'b0;   evt_q <= 1'b1; end
          MD_TGL:   if (hit_pri) begin pin_q <= !pin_q; evt_q <= 1'b1; end
          MD_ONE, MD_CONT: begin
            if (!pin_q) begin
              if (hit_pri && !done) pin_q <= 1'b1;
            end else if (hit_sec) begin
              pin_q <= 1'b0;
              evt_q <= 1'b1;
              done  <= (mode == MD_ONE);
            end
          end
          MD_PWM, MD_PWMF: begin
            if (wrap) begin
              duty  <= sec;
              pin_q <= (sec != '0);
              evt_q <= 1'b1;
            end else if (hit_dty) begin
              pin_q <= 1'b0;
            end
          end
          default: pin_q <= 1'b0;
        endcase
      end
    end
  end

  // R14
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF && !ctl_wr) |=> (!pin_q && !evt_q));

  // R10
  flt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWMF && flt_in && !ctl_wr) |=> (!pin_q && !evt_q && flt_st));

  // R11
  flt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!flt_st && !evt_q));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ctl_wr && !flt_act) |=> ($stable(pin_q) && !evt_q));

  // R9
  flt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_PWMF) |=> !flt_st);

endmodule

// File: tb/out_cmp_chan_tb.sv
`timescale 1ns/1ps
module out_cmp_chan_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] tmr0_cnt = '0, tmr1_cnt = '0, wr_data = '0;
  logic          tmr0_wrap = 1'b0, tmr1_wrap = 1'b0, cpu_idle = 1'b0, flt_in = 1'b0, wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [7:0]    ctl_rd;
  logic          pin_out, cmp_evt;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    logic       pin;
    logic       evt;
    logic       cc;
    logic [7:0] ctl;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  out_cmp_chan #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr0_cnt(tmr0_cnt), .tmr1_cnt(tmr1_cnt),
    .tmr0_wrap(tmr0_wrap), .tmr1_wrap(tmr1_wrap), .cpu_idle(cpu_idle),
    .flt_in(flt_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl_rd(ctl_rd), .pin_out(pin_out), .cmp_evt(cmp_evt));

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pin_out !== e.pin) begin
        fails++;
        $display("FAIL %s pin actual=%b expected=%b", e.tag, pin_out, e.pin);
      end
      checks++;
      if (cmp_evt !== e.evt) begin
        fails++;
        $display("FAIL %s evt actual=%b expected=%b", e.tag, cmp_evt, e.evt);
      end
      if (e.cc) begin
        checks++;
        if (ctl_rd !== e.ctl) begin
          fails++;
          $display("FAIL %s ctl actual=%h expected=%h", e.tag, ctl_rd, e.ctl);
        end
      end
    end
  end

  task automatic cyc(input logic ep, input logic ee, input logic cc,
                     input logic [7:0] ec, input string t);
    exp_t e;
    @(posedge clk);
    #1;
    e.pin = ep; e.evt = ee; e.cc = cc; e.ctl = ec; e.tag = t;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [CW-1:0] d, input logic ep,
                    input logic ee, input logic cc, input logic [7:0] ec, input string t);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc(ep, ee, cc, ec, t);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 1, 8'h00, "R1");
    wr(2'd1, 16'd10, 0, 0, 0, 0, "setup");
    wr(2'd2, 16'd20, 0, 0, 0, 0, "setup");
    // set high on match
    wr(2'd0, 16'h01, 0, 0, 1, 8'h01, "R2");
    tmr0_cnt = 10; cyc(1, 1, 0, 0, "R2");
    tmr0_cnt = 11; cyc(1, 0, 0, 0, "R2");
    // set low on match
    wr(2'd0, 16'h02, 1, 0, 1, 8'h02, "R3");
    tmr0_cnt = 10; cyc(0, 1, 0, 0, "R3");
    tmr0_cnt = 12; cyc(0, 0, 0, 0, "R3");
    // toggle
    wr(2'd0, 16'h03, 0, 0, 1, 8'h03, "R4");
    tmr0_cnt = 10; cyc(1, 1, 0, 0, "R4");
    cyc(0, 1, 0, 0, "R4");
    tmr0_cnt = 5; cyc(0, 0, 0, 0, "R4");
    // timebase select
    wr(2'd0, 16'h0B, 0, 0, 1, 8'h0B, "R5");
    tmr0_cnt = 10; tmr1_cnt = 7; cyc(0, 0, 0, 0, "R5");
    tmr1_cnt = 10; cyc(1, 1, 0, 0, "R5");
    // single pulse
    tmr0_cnt = 0; tmr1_cnt = 0;
    wr(2'd0, 16'h04, 0, 0, 1, 8'h04, "R6");
    tmr0_cnt = 10; cyc(1, 0, 0, 0, "R6");
    tmr0_cnt = 15; cyc(1, 0, 0, 0, "R6");
    tmr0_cnt = 20; cyc(0, 1, 0, 0, "R6");
    tmr0_cnt = 10; cyc(0, 0, 0, 0, "R6");
    tmr0_cnt = 20; cyc(0, 0, 0, 0, "R6");
    // continuous pulses
    wr(2'd0, 16'h05, 0, 0, 1, 8'h05, "R7");
    tmr0_cnt = 10; cyc(1, 0, 0, 0, "R7");
    tmr0_cnt = 20; cyc(0, 1, 0, 0, "R7");
    tmr0_cnt = 10; cyc(1, 0, 0, 0, "R7");
    tmr0_cnt = 20; cyc(0, 1, 0, 0, "R7");
    // PWM, fault ignored
    wr(2'd0, 16'h06, 0, 0, 1, 8'h06, "R8");
    tmr0_cnt = 0; tmr0_wrap = 1; cyc(1, 1, 0, 0, "R8");
    tmr0_wrap = 0; tmr0_cnt = 5; cyc(1, 0, 0, 0, "R8");
    tmr0_cnt = 20; cyc(0, 0, 0, 0, "R8");
    tmr0_cnt = 21; wr(2'd2, 16'd3, 0, 0, 0, 0, "R8");
    tmr0_cnt = 0; tmr0_wrap = 1; cyc(1, 1, 0, 0, "R8");
    tmr0_wrap = 0; tmr0_cnt = 1; wr(2'd2, 16'd20, 1, 0, 0, 0, "R8");
    tmr0_cnt = 3; cyc(0, 0, 0, 0, "R8");
    flt_in = 1; tmr0_cnt = 0; tmr0_wrap = 1; cyc(1, 1, 1, 8'h06, "R9");
    flt_in = 0; tmr0_wrap = 0;
    // PWM with fault
    wr(2'd0, 16'h07, 0, 0, 1, 8'h07, "R10");
    tmr0_cnt = 0; tmr0_wrap = 1; cyc(1, 1, 0, 0, "R10");
    tmr0_wrap = 0; tmr0_cnt = 1; flt_in = 1; cyc(0, 0, 1, 8'h17, "R10");
    flt_in = 0; tmr0_cnt = 0; tmr0_wrap = 1; cyc(0, 0, 1, 8'h17, "R10");
    tmr0_wrap = 0; tmr0_cnt = 2;
    wr(2'd0, 16'h07, 0, 0, 1, 8'h07, "R11");
    tmr0_cnt = 0; tmr0_wrap = 1; flt_in = 1; cyc(0, 0, 1, 8'h17, "R10");
    tmr0_wrap = 0; flt_in = 0; tmr0_cnt = 2;
    wr(2'd0, 16'h17, 0, 0, 1, 8'h07, "R12");
    wr(2'd0, 16'hFF, 0, 0, 1, 8'h2F, "R12");
    // idle stop
    tmr0_cnt = 5;
    wr(2'd0, 16'h23, 0, 0, 1, 8'h23, "R13");
    cpu_idle = 1; tmr0_cnt = 10; cyc(0, 0, 0, 0, "R13");
    cpu_idle = 0; cyc(1, 1, 0, 0, "R13");
    cpu_idle = 1;
    wr(2'd0, 16'h03, 0, 0, 1, 8'h03, "R11");
    cyc(1, 1, 0, 0, "R13");
    cpu_idle = 0;
    // disabled
    wr(2'd0, 16'h00, 0, 0, 1, 8'h00, "R14");
    tmr0_cnt = 10; cyc(0, 0, 0, 0, "R14");
    tmr0_cnt = 20; tmr0_wrap = 1; cyc(0, 0, 0, 0, "R14");
    tmr0_wrap = 0;
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule